// File: doc/BRIEF.md
# Floppy Drive Control Register Set

This block holds the registers a host uses to steer a floppy disk controller and its drives. A small synchronous bus carries an address, separate write and read strobes, an 8-bit write bus and an 8-bit read bus. The read bus comes with a per-bit output-enable vector, so bits that are not driven can be left in high impedance by the pad logic.

Two registers can only be written: a drive control byte and a data rate byte. One register can only be read: a disk-changed status byte. From the drive control byte the block drives four active-low motor lines and four active-low drive selects. A select is gated by the motor bit of the drive it names. The same byte also sets a gate that enables DMA and interrupt signalling, and an active-low soft reset for the controller core. The data rate byte supplies a 2-bit rate code to the core.

The soft reset only holds the core in reset. The hardware reset is the only thing that clears the registers themselves.

Top module: `fdc_ctl_regs`

## Requirements
- R1: After a write to the drive control address (2), bit 4+i of the written byte sets motor line i. A 1 drives `motor_n[i]` low and a 0 drives it high, for i = 0..3.
- R2: After a drive control write, bit 3 of the byte appears on `dma_irq_en`. A 1 enables the DMA and interrupt signals and a 0 forces them inactive.
- R3: Bit 2 of the drive control byte drives `core_rst_n`, where 0 holds the core in reset. Writing it as 0 leaves the motor, select, DMA and data rate state exactly as written.
- R4: Bits 1:0 of the drive control byte name drive 0..3. `dsel_n[d]` is low only when d is the named drive and its motor bit is 1; all other selects stay high, so at most one is low.
- R5: A write to the data rate address (3) loads bits 1:0 into `rate_code` (00 = 500 kb/s, 01 = 300 kb/s, 10 = 250 kb/s, 11 = 1000 kb/s) and ignores bits 7:2. A drive control write leaves `rate_code` unchanged.
- R6: While `rst_n` is low, the drive control byte is 0 and `rate_code` is 10. This gives `motor_n` = 4'hF, `dsel_n` = 4'hF, `dma_irq_en` = 0 and `core_rst_n` = 0.
- R7: Bit 7 of the status byte is the complement of `dskchg_n`, sampled through two synchronizer flops and a status flop. A change on the input shows on the third rising edge after it.
- R8: While a read strobe addresses the status byte (address 3), `bus_rdata_oe` is 8'h80 and bits 6:0 are not driven. With no read strobe, `bus_rdata_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| bus_rdata_oe | output | 8 | Per-bit drive enable for read data |
| dskchg_n | input | 1 | Disk-change input from the drive, active low |
| motor_n | output | 4 | Motor enables, active low |
| dsel_n | output | 4 | Drive selects, active low |
| dma_irq_en | output | 1 | DMA and interrupt gate |
| core_rst_n | output | 1 | Soft reset to controller core, active low |
| rate_code | output | 2 | Data rate code to the core |

## Verification
Register outputs settle one clock after the rising edge that samples the write strobe. The bench drives each write at a falling edge, removes the strobe at the next falling edge, and samples shortly after that. The read bus and its enable follow the read strobe in the same cycle, so reads are checked a moment after the strobe is raised. The disk-changed bit takes three rising edges to follow the input. Its check therefore samples after the second edge and expects the old value, then samples after the third edge and expects the new one.

// File: rtl/fdc_ctl_pkg.sv
package fdc_ctl_pkg;

   typedef enum logic [1:0] {
      RATE_500K = 2'b00,
      RATE_300K = 2'b01,
      RATE_250K = 2'b10,
      RATE_1M   = 2'b11
   } rate_e;

   typedef struct packed {
      logic [3:0] motor_on;
      logic       dma_en;
      logic       run;
      logic [1:0] drive;
   } drvctl_t;

endpackage

// File: rtl/fdc_drive_ctl_reg.sv
module fdc_drive_ctl_reg #(
   parameter int DW         = 8,
   parameter int NUM_DRIVES = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [DW-1:0]         wdata,
   output logic [NUM_DRIVES-1:0] motor_n,
   output logic [NUM_DRIVES-1:0] dsel_n,
   output logic                  dma_gate,
   output logic                  core_rst_n
);
   import fdc_ctl_pkg::*;

   localparam int SEL_W = $clog2(NUM_DRIVES);

   if (DW != $bits(drvctl_t)) begin : g_bad_dw
      $fatal(1, "drive control byte width must match field layout");
   end
   if (NUM_DRIVES != 4) begin : g_bad_drives
      $fatal(1, "field layout carries exactly four drives");
   end

   drvctl_t ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctl_q <= '0;
      else if (wr_en)
         ctl_q <= drvctl_t'(wdata);
   end

   for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drive
      assign motor_n[g] = ~ctl_q.motor_on[g];
      assign dsel_n[g]  = ~((ctl_q.drive == SEL_W'(g)) && ctl_q.motor_on[g]);
   end

   assign dma_gate   = ctl_q.dma_en;
   assign core_rst_n = ctl_q.run;

endmodule

// File: rtl/fdc_rate_reg.sv
module fdc_rate_reg #(
   parameter int               RATE_W     = 2,
   parameter logic [RATE_W-1:0] RESET_CODE = 2'b10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [RATE_W-1:0] wcode,
   output logic [RATE_W-1:0] code
);

   if (RATE_W < 1) begin : g_bad_w
      $fatal(1, "rate code needs at least one bit");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         code <= RESET_CODE;
      else if (wr_en)
         code <= wcode;
   end

endmodule

// File: rtl/fdc_chg_status.sv
module fdc_chg_status #(
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dskchg_n,
   input  logic          rd_sel,
   output logic [DW-1:0] rdata,
   output logic [DW-1:0] rdata_oe
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $fatal(1, "synchronizer needs two or more stages");
   end
   if (DW < 2) begin : g_bad_dw
      $fatal(1, "status byte too narrow");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   chg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         chg_q  <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], dskchg_n};
         chg_q  <= ~sync_q[SYNC_STAGES-1];
      end
   end

   assign rdata    = rd_sel ? {chg_q, {(DW-1){1'b0}}} : '0;
   assign rdata_oe = rd_sel ? {1'b1,  {(DW-1){1'b0}}} : '0;

endmodule

// File: rtl/fdc_ctl_regs.sv
module fdc_ctl_regs #(
   parameter int               DW            = 8,
   parameter int               AW            = 2,
   parameter int               NUM_DRIVES    = 4,
   parameter int               SYNC_STAGES   = 2,
   parameter int               RATE_W        = 2,
   parameter logic [RATE_W-1:0] RATE_RESET    = 2'b10,
   parameter logic [AW-1:0]    ADR_DRIVE_CTL = 2'd2,
   parameter logic [AW-1:0]    ADR_RATE      = 2'd3,
   parameter logic [AW-1:0]    ADR_CHG       = 2'd3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [AW-1:0]         bus_addr,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   input  logic [DW-1:0]         bus_wdata,
   output logic [DW-1:0]         bus_rdata,
   output logic [DW-1:0]         bus_rdata_oe,
   input  logic                  dskchg_n,
   output logic [NUM_DRIVES-1:0] motor_n,
   output logic [NUM_DRIVES-1:0] dsel_n,
   output logic                  dma_irq_en,
   output logic                  core_rst_n,
   output logic [RATE_W-1:0]     rate_code
);

   if (RATE_W > DW) begin : g_bad_rate
      $fatal(1, "rate code wider than bus");
   end
   if (ADR_DRIVE_CTL == ADR_RATE) begin : g_bad_map
      $fatal(1, "write registers share an address");
   end

   logic wr_ctl, wr_rate, rd_chg;

   assign wr_ctl  = bus_wr && (bus_addr == ADR_DRIVE_CTL);
   assign wr_rate = bus_wr && (bus_addr == ADR_RATE);
   assign rd_chg  = bus_rd && (bus_addr == ADR_CHG);

   fdc_drive_ctl_reg #(
      .DW         (DW),
      .NUM_DRIVES (NUM_DRIVES)
   ) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_ctl),
      .wdata      (bus_wdata),
      .motor_n    (motor_n),
      .dsel_n     (dsel_n),
      .dma_gate   (dma_irq_en),
      .core_rst_n (core_rst_n)
   );

   fdc_rate_reg #(
      .RATE_W     (RATE_W),
      .RESET_CODE (RATE_RESET)
   ) u_rate (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_rate),
      .wcode (bus_wdata[RATE_W-1:0]),
      .code  (rate_code)
   );

   fdc_chg_status #(
      .DW          (DW),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_chg (
      .clk      (clk),
      .rst_n    (rst_n),
      .dskchg_n (dskchg_n),
      .rd_sel   (rd_chg),
      .rdata    (bus_rdata),
      .rdata_oe (bus_rdata_oe)
   );

endmodule

// File: rtl/fdc_ctl_regs_chk.sv
module fdc_ctl_regs_chk #(
   parameter int               DW            = 8,
   parameter int               AW            = 2,
   parameter int               NUM_DRIVES    = 4,
   parameter int               RATE_W        = 2,
   parameter logic [AW-1:0]    ADR_DRIVE_CTL = 2'd2,
   parameter logic [AW-1:0]    ADR_RATE      = 2'd3,
   parameter logic [AW-1:0]    ADR_CHG       = 2'd3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [AW-1:0]         bus_addr,
   input logic                  bus_wr,
   input logic                  bus_rd,
   input logic [DW-1:0]         bus_wdata,
   input logic [DW-1:0]         bus_rdata_oe,
   input logic [NUM_DRIVES-1:0] motor_n,
   input logic [NUM_DRIVES-1:0] dsel_n,
   input logic                  dma_irq_en,
   input logic [RATE_W-1:0]     rate_code
);

   p_motor_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADR_DRIVE_CTL) |=> (motor_n == ~$past(bus_wdata[7:4])));

   p_dma_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADR_DRIVE_CTL) |=> (dma_irq_en == $past(bus_wdata[3])));

   p_one_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~dsel_n));

   p_select_needs_motor_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((~dsel_n & motor_n) == '0));

   p_rate_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADR_RATE) |=> (rate_code == $past(bus_wdata[RATE_W-1:0])));

   p_rate_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == ADR_RATE) |=> $stable(rate_code));

   p_oe_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> (bus_rdata_oe == '0));

   p_oe_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADR_CHG) |-> ($countones(bus_rdata_oe) == 1 && bus_rdata_oe[DW-1]));

endmodule

bind fdc_ctl_regs fdc_ctl_regs_chk #(
   .DW            (DW),
   .AW            (AW),
   .NUM_DRIVES    (NUM_DRIVES),
   .RATE_W        (RATE_W),
   .ADR_DRIVE_CTL (ADR_DRIVE_CTL),
   .ADR_RATE      (ADR_RATE),
   .ADR_CHG       (ADR_CHG)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_addr     (bus_addr),
   .bus_wr       (bus_wr),
   .bus_rd       (bus_rd),
   .bus_wdata    (bus_wdata),
   .bus_rdata_oe (bus_rdata_oe),
   .motor_n      (motor_n),
   .dsel_n       (dsel_n),
   .dma_irq_en   (dma_irq_en),
   .rate_code    (rate_code)
);

// File: tb/fdc_ctl_regs_test.sv
module fdc_ctl_regs_test;

   localparam logic [1:0] A_CTL  = 2'd2;
   localparam logic [1:0] A_RATE = 2'd3;
   localparam logic [1:0] A_CHG  = 2'd3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata, bus_rdata_oe;
   logic       dskchg_n = 1'b1;
   logic [3:0] motor_n, dsel_n;
   logic       dma_irq_en, core_rst_n;
   logic [1:0] rate_code;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   fdc_ctl_regs uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_addr     (bus_addr),
      .bus_wr       (bus_wr),
      .bus_rd       (bus_rd),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .bus_rdata_oe (bus_rdata_oe),
      .dskchg_n     (dskchg_n),
      .motor_n      (motor_n),
      .dsel_n       (dsel_n),
      .dma_irq_en   (dma_irq_en),
      .core_rst_n   (core_rst_n),
      .rate_code    (rate_code)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      #1;
   endtask

   task automatic hw_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   function automatic logic [3:0] exp_sel(input logic [3:0] m, input logic [1:0] d);
      return m[d] ? ~(4'b0001 << d) : 4'hF;
   endfunction

   task automatic t_reset_state();
      check(motor_n == 4'hF, "R6 motors off", motor_n, 4'hF);
      check(dsel_n == 4'hF, "R6 no select", dsel_n, 4'hF);
      check(dma_irq_en == 1'b0, "R6 dma gate", dma_irq_en, 0);
      check(core_rst_n == 1'b0, "R6 core held", core_rst_n, 0);
      check(rate_code == 2'b10, "R6 rate default", rate_code, 2);
      check(bus_rdata_oe == 8'h00, "R8 idle oe", bus_rdata_oe, 0);
   endtask

   task automatic t_select_sweep();
      for (int d = 0; d < 4; d++) begin
         for (int m = 0; m < 16; m++) begin
            bus_write(A_CTL, {m[3:0], 2'b11, d[1:0]});
            check(motor_n == ~m[3:0], "R1 motor line", motor_n, ~m[3:0]);
            check(dsel_n == exp_sel(m[3:0], d[1:0]), "R4 select gating",
                  dsel_n, exp_sel(m[3:0], d[1:0]));
         end
      end
   endtask

   task automatic t_dma_gate();
      bus_write(A_CTL, 8'b0000_1100);
      check(dma_irq_en == 1'b1, "R2 dma on", dma_irq_en, 1);
      bus_write(A_CTL, 8'b0000_0100);
      check(dma_irq_en == 1'b0, "R2 dma off", dma_irq_en, 0);
   endtask

   task automatic t_soft_reset();
      bus_write(A_RATE, 8'h01);
      bus_write(A_CTL, 8'b0101_1110);
      check(core_rst_n == 1'b1, "R3 core runs", core_rst_n, 1);
      bus_write(A_CTL, 8'b0101_1010);
      check(core_rst_n == 1'b0, "R3 core held", core_rst_n, 0);
      check(motor_n == 4'b1010, "R3 motors kept", motor_n, 4'b1010);
      check(dsel_n == 4'b1011, "R3 select kept", dsel_n, 4'b1011);
      check(dma_irq_en == 1'b1, "R3 dma kept", dma_irq_en, 1);
      check(rate_code == 2'b01, "R3 rate kept", rate_code, 1);
   endtask

   task automatic t_rate();
      bus_write(A_RATE, 8'hFF);
      check(rate_code == 2'b11, "R5 rate 11", rate_code, 3);
      bus_write(A_RATE, 8'hFC);
      check(rate_code == 2'b00, "R5 upper bits ignored", rate_code, 0);
      bus_write(A_RATE, 8'hA5);
      check(rate_code == 2'b01, "R5 rate 01", rate_code, 1);
      bus_write(A_CTL, 8'hF2);
      check(rate_code == 2'b01, "R5 ctl write leaves rate", rate_code, 1);
   endtask

   task automatic t_hw_reset();
      bus_write(A_CTL, 8'b1111_1101);
      bus_write(A_RATE, 8'h03);
      hw_reset();
      t_reset_state();
   endtask

   task automatic t_disk_change();
      @(negedge clk);
      bus_addr = A_CHG;
      bus_rd   = 1'b1;
      #1;
      check(bus_rdata_oe == 8'h80, "R8 status oe", bus_rdata_oe, 8'h80);
      check(bus_rdata[7] == 1'b0, "R7 no change yet", bus_rdata[7], 0);
      @(negedge clk);
      dskchg_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      #1;
      check(bus_rdata[7] == 1'b0, "R7 two edges old", bus_rdata[7], 0);
      @(negedge clk);
      #1;
      check(bus_rdata[7] == 1'b1, "R7 third edge new", bus_rdata[7], 1);
      check(bus_rdata_oe == 8'h80, "R8 only bit 7 driven", bus_rdata_oe, 8'h80);
      dskchg_n = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      check(bus_rdata[7] == 1'b0, "R7 cleared", bus_rdata[7], 0);
      bus_rd = 1'b0;
      #1;
      check(bus_rdata_oe == 8'h00, "R8 released", bus_rdata_oe, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset_state();
      t_select_sweep();
      t_dma_gate();
      t_soft_reset();
      t_rate();
      t_disk_change();
      t_hw_reset();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule